// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is the only master on an I2C bus and carries out one primitive bus action per host request: a start condition, a repeated start, a stop condition, a byte write, or a byte read that ends with either an acknowledge or a not-acknowledge. The host places a 3-bit operation code and, for writes, a data byte on the inputs, then pulses `go` for one clock. While the action runs, `done` is low. When the action finishes, `done` returns high and stays high. After a write, the slave's acknowledge level is presented on `slv_ack`. After a read, the received byte is presented on `rd_byte`.

Every bit slot and every bus condition is built from four equal quarter periods, A to D. Each quarter lasts `TICK_NUM + 2` clocks, so `TICK_NUM = fclk/(4*bitrate) - 2`. For example, a value of 123 gives 100 kbit/s from a 50 MHz clock. The bus side is split into a clock drive, a data drive and a data sense line. On both drive lines, 0 means pull low and 1 means release, so open-drain buffers are placed outside the block. The master never senses the clock line, so a slave that stretches the clock is not waited for.

Top module: `i2c_byte_master`

## Requirements
- R1: On reset, and after a reset that interrupts an operation, `scl_drv` = 1, `sda_drv` = 1 and `done` = 1.
- R2: `op_code` is decoded as follows: 000 start, 001 repeated start, 010 stop, 011 write byte, 100 read byte then ACK. The values 101, 110 and 111 all mean read byte then NACK.
- R3: `op_code` and `wr_byte` are captured only in the cycle in which `go` is accepted. A `go` pulse, or a change of `op_code` or `wr_byte`, while an operation runs has no effect on that operation.
- R4: A quarter phase lasts `TICK_NUM+2` clocks. `done` rises exactly `4*(TICK_NUM+2)` clocks after the accepting edge for start, repeated start and stop, and exactly `36*(TICK_NUM+2)` clocks after it for byte operations.
- R5: `done` is low from the clock after an accepted `go` until the operation ends. It then stays high until the next accepted `go`.
- R6: A write sends `wr_byte` MSB first, one bit per SCL high period. In the ninth slot the master releases SDA. The level it samples there is placed on `slv_ack`.
- R7: A read releases SDA for eight slots and samples the bus while SCL is high, MSB first, into `rd_byte`. In the ninth slot the master drives SDA low for code 100 and releases it for the read-with-NACK codes.
- R8: A start ends with both drive lines low and gives exactly one SDA fall while SCL is high. A repeated start does the same, starting from SCL low. A stop gives exactly one SDA rise while SCL is high and ends with both lines released.
- R9: During byte operations, SDA changes only while SCL is low. No start or stop condition appears on the bus.
- R10: `rd_byte` changes only at the end of a read, and `slv_ack` changes only at the end of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle request pulse |
| op_code | input | 3 | Operation code, captured with `go` |
| wr_byte | input | DATA_W | Byte to send on a write, captured with `go` |
| done | output | 1 | High when idle; low while an operation runs |
| rd_byte | output | DATA_W | Byte received by the last read |
| slv_ack | output | 1 | Acknowledge level sampled on the last write |
| scl_drv | output | 1 | Clock line drive: 0 pulls low, 1 releases |
| sda_drv | output | 1 | Data line drive: 0 pulls low, 1 releases |
| sda_in | input | 1 | Sensed level of the data line |

## Verification
The bench attaches a slave model that changes SDA only on falling SCL edges, and a bus monitor that counts SDA edges seen while SCL is high. A data bit that moves while SCL is high therefore shows up as a false start or stop. A byte sent LSB first or shifted at the wrong phase yields the wrong monitored byte. The unused codes 110 and 111 are exercised, so a decoder that maps them to anything but read-with-NACK shows a driven ACK bit or a wrong duration. A second `go` with a different code and byte is fired mid-write, which catches a design that re-captures its inputs. The bench also resets the block mid-byte to catch lines left low. It checks `rd_byte` and `slv_ack` across unrelated operations to catch an output that is overwritten when it should not be.

// File: rtl/i2c_bytemaster_pkg.sv
`timescale 1ns/1ps
package i2c_bytemaster_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_RD_ACK  = 3'd4,
    OP_RD_NACK = 3'd5
  } bus_op_e;

  typedef enum logic [1:0] {PH_A, PH_B, PH_C, PH_D} quarter_e;

  // Unused codes fold onto read-with-NACK.
  function automatic bus_op_e decode_op(input logic [2:0] code);
    if (code > 3'd4) return OP_RD_NACK;
    return bus_op_e'(code);
  endfunction

  function automatic logic is_byte_op(input bus_op_e op);
    return (op == OP_WRITE) || (op == OP_RD_ACK) || (op == OP_RD_NACK);
  endfunction

  // Returns {scl, sda} for the given operation and quarter; b is the slot bit.
  function automatic logic [1:0] line_levels(input bus_op_e op, input quarter_e ph,
                                             input logic b);
    logic mid;
    mid = (ph == PH_B) || (ph == PH_C);
    case (op)
      OP_START:   return {ph != PH_D, (ph == PH_A) || (ph == PH_B)};
      OP_RESTART: return {mid, (ph == PH_A) || (ph == PH_B)};
      OP_STOP:    return {ph != PH_A, (ph == PH_C) || (ph == PH_D)};
      default:    return {mid, b};
    endcase
  endfunction

endpackage

// File: rtl/i2c_quarter_timer.sv
`timescale 1ns/1ps
module i2c_quarter_timer #(
  parameter int TICK_NUM = 123
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic quarter_end
);
  localparam int QLEN = TICK_NUM + 2;
  localparam int CW   = $clog2(QLEN + 1);
  localparam logic [CW-1:0] LAST = CW'(QLEN - 1);

  logic [CW-1:0] cnt;

  assign quarter_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (quarter_end) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

endmodule

// File: rtl/i2c_slot_sequencer.sv
`timescale 1ns/1ps
module i2c_slot_sequencer
  import i2c_bytemaster_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SW = $clog2(DATA_W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          quarter_end,
  input  logic          byte_op,
  output quarter_e      phase,
  output logic [SW-1:0] slot,
  output logic          op_end
);
  localparam logic [SW-1:0] ACK_SLOT = SW'(DATA_W);

  logic [SW-1:0] last_slot;

  assign last_slot = byte_op ? ACK_SLOT : '0;
  assign op_end    = quarter_end && (phase == PH_D) && (slot == last_slot);

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      phase <= PH_A;
      slot  <= '0;
    end else if (quarter_end) begin
      phase <= quarter_e'(phase + 2'd1);
      if (op_end)              slot <= '0;
      else if (phase == PH_D)  slot <= slot + 1'b1;
    end
  end

  p_slot_bound_r6: assert property (@(posedge clk) disable iff (rst)
    slot <= ACK_SLOT);

  p_end_in_d_r4: assert property (@(posedge clk) disable iff (rst)
    op_end |=> (phase == PH_A));

endmodule

// File: rtl/i2c_byte_shifter.sv
`timescale 1ns/1ps
module i2c_byte_shifter
  import i2c_bytemaster_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  bus_op_e           op,
  input  quarter_e          phase,
  input  logic [SW-1:0]     slot,
  input  logic              quarter_end,
  input  logic              op_end,
  input  logic              sda_in,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack
);
  localparam logic [SW-1:0] ACK_SLOT = SW'(DATA_W);

  logic [DATA_W-1:0] sh;
  logic data_slot, sample_pt, is_rd;

  assign data_slot = slot < ACK_SLOT;
  assign sample_pt = quarter_end && (phase == PH_B);
  assign is_rd     = (op == OP_RD_ACK) || (op == OP_RD_NACK);

  always_comb begin
    if (op == OP_WRITE)      tx_bit = data_slot ? sh[DATA_W-1] : 1'b1;
    else if (op == OP_RD_ACK) tx_bit = data_slot;
    else                     tx_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      rd_data <= '0;
      ack     <= 1'b1;
    end else begin
      if (load)
        sh <= wdata;
      else if ((op == OP_WRITE) && quarter_end && (phase == PH_D) && data_slot)
        sh <= {sh[DATA_W-2:0], 1'b0};
      else if (is_rd && sample_pt && data_slot)
        sh <= {sh[DATA_W-2:0], sda_in};
      if ((op == OP_WRITE) && sample_pt && (slot == ACK_SLOT))
        ack <= sda_in;
      if (is_rd && op_end)
        rd_data <= sh;
    end
  end

endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
  import i2c_bytemaster_pkg::*;
#(
  parameter int TICK_NUM = 123,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              done,
  output logic [DATA_W-1:0] rd_byte,
  output logic              slv_ack,
  output logic              scl_drv,
  output logic              sda_drv,
  input  logic              sda_in
);
  localparam int SW = $clog2(DATA_W + 2);

  bus_op_e       op_q;
  quarter_e      phase;
  logic [SW-1:0] slot;
  logic          busy, launch, qend, op_end, tx_bit;
  logic [1:0]    lv;

  assign launch = go && !busy;
  assign lv     = line_levels(op_q, phase, tx_bit);

  i2c_quarter_timer #(.TICK_NUM(TICK_NUM)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .quarter_end(qend)
  );

  i2c_slot_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .quarter_end(qend),
    .byte_op(is_byte_op(op_q)), .phase(phase), .slot(slot), .op_end(op_end)
  );

  i2c_byte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(launch), .wdata(wr_byte), .op(op_q),
    .phase(phase), .slot(slot), .quarter_end(qend), .op_end(op_end),
    .sda_in(sda_in), .tx_bit(tx_bit), .rd_data(rd_byte), .ack(slv_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b1;
      op_q    <= OP_START;
      scl_drv <= 1'b1;
      sda_drv <= 1'b1;
    end else begin
      if (launch) begin
        busy <= 1'b1;
        done <= 1'b0;
        op_q <= decode_op(op_code);
      end else if (op_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (busy) {scl_drv, sda_drv} <= lv;
    end
  end

  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> done);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (go && done) |=> !done);

  p_sda_data_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && is_byte_op(op_q) && scl_drv && $past(scl_drv)) |-> $stable(sda_drv));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(scl_drv) && $stable(sda_drv)));

  p_outs_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(rd_byte) && $stable(slv_ack)));

endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  localparam int TICKS = 2;
  localparam int QL    = TICKS + 2;
  localparam int NV    = 11;
  // {op[2:0], wr_byte[7:0], slave byte[7:0], slave ack}
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 8'h00, 8'h00, 1'b0},
    {3'd3, 8'hA5, 8'h00, 1'b0},
    {3'd3, 8'h3C, 8'h00, 1'b1},
    {3'd4, 8'h00, 8'h5A, 1'b0},
    {3'd1, 8'h00, 8'h00, 1'b0},
    {3'd3, 8'h81, 8'h00, 1'b0},
    {3'd5, 8'h00, 8'hC3, 1'b0},
    {3'd1, 8'h00, 8'h00, 1'b0},
    {3'd6, 8'h00, 8'h0F, 1'b0},
    {3'd7, 8'h00, 8'hF0, 1'b0},
    {3'd2, 8'h00, 8'h00, 1'b0}
  };

  logic clk = 0, rst = 1, go = 0;
  logic [2:0] op_code = '0;
  logic [7:0] wr_byte = '0;
  logic done, slv_ack, scl_drv, sda_drv;
  logic [7:0] rd_byte;
  logic slv_sda = 1'b1, slv_act = 1'b0;
  logic [8:0] slv_pat = '1;
  int slv_idx = 0;
  logic [8:0] mon_sh = '0;
  int mon_n = 0, n_start = 0, n_stop = 0;
  int checks = 0, fails = 0;
  logic [7:0] prev_rd;
  logic prev_ack;
  wire sda_bus = sda_drv & slv_sda;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.TICK_NUM(TICKS), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .go(go), .op_code(op_code), .wr_byte(wr_byte),
    .done(done), .rd_byte(rd_byte), .slv_ack(slv_ack),
    .scl_drv(scl_drv), .sda_drv(sda_drv), .sda_in(sda_bus)
  );

  always @(negedge scl_drv) if (slv_act) begin
    slv_idx = slv_idx + 1;
    slv_sda = (slv_idx < 9) ? slv_pat[8 - slv_idx] : 1'b1;
  end

  always @(posedge scl_drv) begin
    mon_sh = {mon_sh[7:0], sda_bus};
    mon_n  = mon_n + 1;
  end
  always @(negedge sda_bus) if (scl_drv === 1'b1) n_start = n_start + 1;
  always @(posedge sda_bus) if (scl_drv === 1'b1) n_stop  = n_stop + 1;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] oc, input logic [7:0] wd, input logic [7:0] sb,
                        input logic sa, input logic poke);
    int n;
    logic is_byte, is_wr, is_rd;
    logic [1:0] endlv;
    is_byte = oc >= 3'd3;
    is_wr   = oc == 3'd3;
    is_rd   = oc >= 3'd4;
    @(negedge clk);
    if (is_byte) begin
      slv_pat = is_wr ? {8'hFF, sa} : {sb, 1'b1};
      slv_idx = 0;
      slv_sda = slv_pat[8];
      slv_act = 1'b1;
    end
    mon_n = 0; n_start = 0; n_stop = 0;
    op_code = oc; wr_byte = wd; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    n = 0;
    chk("R5 done low after go", done, 1'b0);
    while (!done && n < 5000) begin
      if (poke && n == 10) begin go = 1'b1; op_code = 3'd2; wr_byte = ~wd; end
      if (poke && n == 11) go = 1'b0;
      @(negedge clk);
      n++;
    end
    slv_act = 1'b0;
    slv_sda = 1'b1;
    chk(poke ? "R3 duration with ignored go" : "R4 operation duration", n,
        (is_byte ? 36 : 4) * QL);
    chk(is_byte ? "R9 no start in byte" : "R8 start count", n_start,
        (oc == 3'd0 || oc == 3'd1) ? 1 : 0);
    chk(is_byte ? "R9 no stop in byte" : "R8 stop count", n_stop, (oc == 3'd2) ? 1 : 0);
    if (is_byte) chk("R6 nine clock pulses", mon_n, 9);
    if (is_wr) begin
      chk(poke ? "R3 byte captured at go" : "R6 byte on bus MSB first", mon_sh[8:1], wd);
      chk("R6 ack sampled", slv_ack, sa);
    end
    if (is_rd) begin
      chk("R7 read data", rd_byte, sb);
      chk("R7 master released data", mon_sh[8:1], sb);
      chk("R2 R7 ack bit by code", mon_sh[0], (oc == 3'd4) ? 1'b0 : 1'b1);
    end
    case (oc)
      3'd0, 3'd1: endlv = 2'b00;
      3'd2:       endlv = 2'b11;
      3'd4:       endlv = 2'b00;
      default:    endlv = 2'b01;
    endcase
    chk("R8 end line levels", {scl_drv, sda_drv}, endlv);
    if (!is_rd) chk("R10 rd_byte kept", rd_byte, prev_rd);
    if (!is_wr) chk("R10 slv_ack kept", slv_ack, prev_ack);
    prev_rd  = rd_byte;
    prev_ack = slv_ack;
    repeat (3) @(negedge clk);
    chk("R5 done held", done, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 reset scl", scl_drv, 1'b1);
    chk("R1 reset sda", sda_drv, 1'b1);
    chk("R1 reset done", done, 1'b1);
    prev_rd  = rd_byte;
    prev_ack = slv_ack;

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][19:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0], 1'b0);

    // R3: a second go with a different op and byte mid-write is ignored
    run_op(3'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    run_op(3'd3, 8'h6E, 8'h00, 1'b0, 1'b1);
    run_op(3'd2, 8'h00, 8'h00, 1'b0, 1'b0);

    // R1: reset in the middle of a byte releases the bus
    @(negedge clk);
    op_code = 3'd3; wr_byte = 8'h00; go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl after mid-op reset", scl_drv, 1'b1);
    chk("R1 sda after mid-op reset", sda_drv, 1'b1);
    chk("R1 done after mid-op reset", done, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule